// File: doc/BRIEF.md
# Fixed-point to float converter

This block decodes one 32-bit scalar instruction that converts a fixed-point value held in a general register into an IEEE 754 floating-point number. It also computes that result. The instruction word says several things: whether the source is signed or unsigned, whether it is 32 or 64 bits wide, whether the output is single or double precision, and how many of the source bits lie below the binary point. The number of fraction bits is sixty-four minus a 6-bit scale field. The caller supplies the register operand and a 2-bit rounding-mode field from its floating-point control register. One clock later the block returns the rounded result, the two register indices taken from the word, an undefined-encoding flag and an inexact flag.

The result equals the exact source value divided by two to the power of the fraction-bit count, rounded once in the selected mode. A single-precision result sits in the low 32 bits of the result port, and the upper 32 bits are zero. Half precision, reserved type codes and a malformed 32-bit-source scale are all treated as undefined encodings.

Top module: `fix2flt_cvt`

## Requirements
- R1: The word is recognised only when bits 30:24 equal 0011110 and bits 21:17 equal 00001. Bit 16 selects unsigned (1) or signed (0). Any other word raises undefEnc. Every output is registered, so it reflects the inputs of the previous rising clock edge.
- R2: undefEnc is raised when type bits 23:22 are 10 or 11, or when bit 31 (sf) is 0 and bit 15 (scale bit 5) is 0. While undefEnc is high, result is zero and inexact is low.
- R3: Type 00 gives single precision in result[31:0] with result[63:32] zero. Type 01 gives double precision in all 64 bits.
- R4: With sf = 1 the whole 64-bit operand is converted. With sf = 0 only bits 31:0 are used, sign-extended for the signed form and zero-extended for the unsigned form.
- R5: The fraction-bit count is 64 minus the unsigned scale field in bits 15:10. A scale of 0 therefore gives 64 fraction bits, and a scale of 63 gives 1.
- R6: The signed form reads the operand as two's complement. The most negative 64-bit value converts to an exact negative power of two.
- R7: The unsigned form reads the operand as a magnitude. An all-ones 64-bit operand rounds up into the next binade when the mode requires it.
- R8: roundMode 00 rounds to nearest with ties to even. 01 rounds toward plus infinity, 10 toward minus infinity, and 11 toward zero.
- R9: inexact is high exactly when nonzero bits are discarded while rounding a defined conversion.
- R10: A zero source yields positive zero with inexact low, in either form.
- R11: dstReg and srcReg carry bits 4:0 and 9:5 of the word, whether or not the encoding is defined.
- R12: While rstN is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 32 | Instruction word to decode |
| srcOperand | input | 64 | General-register operand |
| roundMode | input | 2 | Rounding mode from the control register |
| result | output | 64 | Converted floating-point value |
| dstReg | output | 5 | Destination register index |
| srcReg | output | 5 | Source register index |
| undefEnc | output | 1 | Word is not a defined conversion |
| inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The bench builds the block with its default widths: a 64-bit operand, a 32-bit word and a 6-bit scale. This puts the whole fraction-bit range from 1 to 64 within reach. The extremes of the exponent, from the smallest unit at 64 fraction bits to the largest all-ones magnitude with one fraction bit, land in both output formats. Because the double-precision path keeps 53 of 64 bits, the tie, sticky and carry-into-next-binade cases show up there and in the single-precision path alike.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;
  parameter int INSTR_W   = 32;
  parameter int XLEN      = 64;
  parameter int SCALE_W   = 6;
  parameter int REG_IDX_W = 5;
  localparam int FRAC_W   = SCALE_W + 1;
  localparam int LZ_W     = $clog2(XLEN);
  localparam int HALF_W   = XLEN / 2;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_POS     = 2'b01,
    RND_NEG     = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic              convEn;
    logic              srcSigned;
    logic              srcWide;
    logic              dblOut;
    logic [FRAC_W-1:0] fracBits;
    rnd_e              rnd;
  } cvt_strobe_t;
endpackage

// File: rtl/fxcvt_ctrl.sv
module fxcvt_ctrl
  import fxcvt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [1:0]           roundMode,
  output cvt_strobe_t          strobe,
  output logic                 undefEnc,
  output logic [REG_IDX_W-1:0] dstReg,
  output logic [REG_IDX_W-1:0] srcReg
);
  logic               sfBit;
  logic               classHit;
  logic [1:0]         typeCode;
  logic [SCALE_W-1:0] scaleField;
  logic               badType;
  logic               badScale;
  logic               isUndef;

  always_comb begin
    sfBit      = instrWord[31];
    typeCode   = instrWord[23:22];
    scaleField = instrWord[15:10];
    classHit   = (instrWord[30:24] == 7'b0011110) && (instrWord[21:17] == 5'b00001);
    // only 00 (single) and 01 (double) are accepted
    badType    = typeCode[1];
    badScale   = !sfBit && !scaleField[SCALE_W-1];
    isUndef    = !classHit || badType || badScale;

    strobe.convEn    = !isUndef;
    strobe.srcSigned = !instrWord[16];
    strobe.srcWide   = sfBit;
    strobe.dblOut    = typeCode[0];
    strobe.fracBits  = FRAC_W'(XLEN) - FRAC_W'(scaleField);
    strobe.rnd       = rnd_e'(roundMode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      undefEnc <= 1'b0;
      dstReg   <= '0;
      srcReg   <= '0;
    end else begin
      undefEnc <= isUndef;
      dstReg   <= instrWord[REG_IDX_W-1:0];
      srcReg   <= instrWord[2*REG_IDX_W-1:REG_IDX_W];
    end
  end
endmodule

// File: rtl/fxcvt_round.sv
module fxcvt_round
  import fxcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [XLEN-1:0]   norm,
  input  logic [LZ_W-1:0]   lz,
  input  logic [FRAC_W-1:0] fracBits,
  input  logic              neg,
  input  rnd_e              rnd,
  output logic [XLEN-1:0]   packedOut,
  output logic              inexact
);
  localparam int KEEP = MAN_W + 1;
  localparam int DROP = XLEN - KEEP;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [KEEP-1:0]  keepBits;
  logic             guardBit;
  logic             stickyBit;
  logic             bump;
  logic [KEEP:0]    sum;
  logic             carry;
  logic             hidden;
  logic [EXP_W-1:0] expField;

  always_comb begin
    keepBits  = norm[XLEN-1 -: KEEP];
    guardBit  = norm[DROP-1];
    stickyBit = |norm[DROP-2:0];
    unique case (rnd)
      RND_NEAREST: bump = guardBit && (stickyBit || keepBits[0]);
      RND_POS:     bump = !neg && (guardBit || stickyBit);
      RND_NEG:     bump = neg && (guardBit || stickyBit);
      default:     bump = 1'b0;
    endcase
    sum      = {1'b0, keepBits} + {{KEEP{1'b0}}, bump};
    carry    = sum[KEEP];
    hidden   = sum[MAN_W];
    // msb weight is (XLEN-1-lz) before the fraction scaling
    expField = EXP_W'(XLEN - 1 + BIAS) - EXP_W'(lz) - EXP_W'(fracBits) + EXP_W'(carry);
    // a zero magnitude leaves neither hidden bit nor carry set
    packedOut = (hidden || carry) ? XLEN'({neg, expField, sum[MAN_W-1:0]}) : '0;
    inexact   = guardBit || stickyBit;
  end
endmodule

// File: rtl/fxcvt_datapath.sv
module fxcvt_datapath
  import fxcvt_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  cvt_strobe_t     strobe,
  input  logic [XLEN-1:0] srcOperand,
  output logic [XLEN-1:0] result,
  output logic            inexact
);
  localparam int NUM_FMT = 2;

  logic [XLEN-1:0] opnd;
  logic            neg;
  logic [XLEN-1:0] mag;
  logic [LZ_W-1:0] lz;
  logic [XLEN-1:0] norm;
  logic [XLEN-1:0] fmtRes [NUM_FMT];
  logic            fmtInx [NUM_FMT];

  always_comb begin
    if (strobe.srcWide)
      opnd = srcOperand;
    else if (strobe.srcSigned)
      opnd = {{HALF_W{srcOperand[HALF_W-1]}}, srcOperand[HALF_W-1:0]};
    else
      opnd = {{HALF_W{1'b0}}, srcOperand[HALF_W-1:0]};
    neg = strobe.srcSigned && opnd[XLEN-1];
    // negating the most negative value yields its true magnitude as unsigned
    mag = neg ? (~opnd + XLEN'(1)) : opnd;
  end

  always_comb begin
    lz = '0;
    for (int i = 0; i < XLEN; i++) begin
      if (mag[i]) lz = LZ_W'(XLEN - 1 - i);
    end
    norm = mag << lz;
  end

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    localparam int EW = (f == 0) ? 8 : 11;
    localparam int MW = (f == 0) ? 23 : 52;
    fxcvt_round #(.EXP_W(EW), .MAN_W(MW)) u_rnd (
      .norm      (norm),
      .lz        (lz),
      .fracBits  (strobe.fracBits),
      .neg       (neg),
      .rnd       (strobe.rnd),
      .packedOut (fmtRes[f]),
      .inexact   (fmtInx[f])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      inexact <= 1'b0;
    end else if (strobe.convEn) begin
      result  <= fmtRes[strobe.dblOut];
      inexact <= fmtInx[strobe.dblOut];
    end else begin
      result  <= '0;
      inexact <= 1'b0;
    end
  end
endmodule

// File: rtl/fix2flt_cvt.sv
module fix2flt_cvt
  import fxcvt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [XLEN-1:0]      srcOperand,
  input  logic [1:0]           roundMode,
  output logic [XLEN-1:0]      result,
  output logic [REG_IDX_W-1:0] dstReg,
  output logic [REG_IDX_W-1:0] srcReg,
  output logic                 undefEnc,
  output logic                 inexact
);
  cvt_strobe_t strobe;

  fxcvt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .roundMode (roundMode),
    .strobe    (strobe),
    .undefEnc  (undefEnc),
    .dstReg    (dstReg),
    .srcReg    (srcReg)
  );

  fxcvt_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcOperand (srcOperand),
    .result     (result),
    .inexact    (inexact)
  );
endmodule

// File: rtl/fix2flt_cvt_chk.sv
module fix2flt_cvt_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instrWord,
  input logic [63:0] srcOperand,
  input logic [63:0] result,
  input logic [4:0]  dstReg,
  input logic [4:0]  srcReg,
  input logic        undefEnc,
  input logic        inexact
);
  // R2
  sf0_scale_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!instrWord[31] && !instrWord[15]) |=> undefEnc);

  // R2
  half_type_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[23:22] == 2'b11) |=> undefEnc);

  // R2
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    undefEnc |-> (result == 64'd0 && !inexact));

  // R3
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[23:22] == 2'b00) |=> (result[63:32] == 32'd0));

  // R10
  zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcOperand == 64'd0) |=> (result == 64'd0 && !inexact));

  // R11
  reg_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dstReg == $past(instrWord[4:0]) && srcReg == $past(instrWord[9:5])));

  // R6
  neg_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[31:22] == 10'b1001111001 && instrWord[21:16] == 6'b000010 && srcOperand[63])
      |=> result[63]);
endmodule

bind fix2flt_cvt fix2flt_cvt_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrWord  (instrWord),
  .srcOperand (srcOperand),
  .result     (result),
  .dstReg     (dstReg),
  .srcReg     (srcReg),
  .undefEnc   (undefEnc),
  .inexact    (inexact)
);

// File: tb/test_fix2flt_cvt.sv
`timescale 1ns/1ps
module test_fix2flt_cvt;
  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] instrWord;
  logic [63:0] srcOperand;
  logic [1:0]  roundMode;
  logic [63:0] result;
  logic [4:0]  dstReg;
  logic [4:0]  srcReg;
  logic        undefEnc;
  logic        inexact;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fix2flt_cvt i_fix2flt_cvt (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .srcOperand(srcOperand),
    .roundMode(roundMode), .result(result), .dstReg(dstReg), .srcReg(srcReg),
    .undefEnc(undefEnc), .inexact(inexact)
  );

  function automatic logic [31:0] mkWord(input logic sf, input logic uns, input logic [1:0] typ,
                                         input logic [5:0] scale, input logic [4:0] rn,
                                         input logic [4:0] rd);
    return {sf, 7'b0011110, typ, 5'b00001, uns, scale, rn, rd};
  endfunction

  // independent model: locate the top bit, compare the remainder against one half
  function automatic void refModel(input logic [31:0] iw, input logic [63:0] src,
                                   input logic [1:0] rm, output logic [63:0] eRes,
                                   output logic eUnd, output logic eInx);
    logic        sf, uns, dbl, neg, up;
    logic [63:0] v, mag, kp, rem, half, frac;
    int          fb, k, p, sh, e;
    eRes = 64'd0;
    eInx = 1'b0;
    sf   = iw[31];
    eUnd = (iw[30:24] != 7'b0011110) || (iw[21:17] != 5'b00001) || iw[23] || (!sf && !iw[15]);
    if (eUnd) return;
    uns = iw[16];
    dbl = iw[22];
    fb  = 64 - int'(iw[15:10]);
    if (sf) v = src;
    else if (uns) v = {32'd0, src[31:0]};
    else v = {{32{src[31]}}, src[31:0]};
    neg = !uns && v[63];
    mag = neg ? (64'd0 - v) : v;
    if (mag == 64'd0) return;
    k = dbl ? 53 : 24;
    p = 0;
    for (int i = 63; i >= 0; i--) begin
      if (mag[i]) begin
        p = i;
        break;
      end
    end
    if (p >= k) begin
      sh   = p - k + 1;
      kp   = mag >> sh;
      rem  = mag & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      eInx = (rem != 64'd0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && kp[0]);
        2'b01:   up = eInx && !neg;
        2'b10:   up = eInx && neg;
        default: up = 1'b0;
      endcase
      kp = kp + {63'd0, up};
      if (kp == (64'd1 << k)) begin
        kp = kp >> 1;
        p  = p + 1;
      end
    end else begin
      kp = mag << (k - 1 - p);
    end
    e    = p - fb + (dbl ? 1023 : 127);
    frac = kp & ((64'd1 << (k - 1)) - 64'd1);
    if (dbl) eRes = {neg, 11'(e), frac[51:0]};
    else     eRes = {32'd0, neg, 8'(e), frac[22:0]};
  endfunction

  task automatic runVec(input logic [31:0] iw, input logic [63:0] src, input logic [1:0] rm,
                        input string tag);
    logic [63:0] eRes;
    logic        eUnd, eInx;
    @(negedge clk);
    instrWord  = iw;
    srcOperand = src;
    roundMode  = rm;
    @(posedge clk);
    #1;
    refModel(iw, src, rm, eRes, eUnd, eInx);
    checks++;
    if (result !== eRes || undefEnc !== eUnd || inexact !== eInx ||
        dstReg !== iw[4:0] || srcReg !== iw[9:5]) begin
      errors++;
      $display("FAIL %s word=%h src=%h rm=%b: res=%h und=%b inx=%b rd=%0d rn=%0d expected res=%h und=%b inx=%b rd=%0d rn=%0d",
               tag, iw, src, rm, result, undefEnc, inexact, dstReg, srcReg,
               eRes, eUnd, eInx, iw[4:0], iw[9:5]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [63:0] s;
    void'($urandom(32'd4242));
    rstN       = 1'b0;
    instrWord  = mkWord(1'b1, 1'b0, 2'b01, 6'd63, 5'd3, 5'd7);
    srcOperand = 64'hFFFF_0000_1234_5678;
    roundMode  = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset holds every output at zero
    checks++;
    if (result !== 64'd0 || undefEnc !== 1'b0 || inexact !== 1'b0 || dstReg !== 5'd0 || srcReg !== 5'd0) begin
      errors++;
      $display("FAIL R12 res=%h und=%b inx=%b rd=%0d rn=%0d expected all zero",
               result, undefEnc, inexact, dstReg, srcReg);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R5 scale 0 means 64 fraction bits; scale 63 means one
    runVec(mkWord(1'b1, 1'b1, 2'b01, 6'd0, 5'd1, 5'd2), 64'd1, 2'b00, "R5 fb64");
    runVec(mkWord(1'b1, 1'b1, 2'b00, 6'd63, 5'd4, 5'd5), 64'd3, 2'b00, "R5 fb1");
    // R6 most negative signed values
    runVec(mkWord(1'b1, 1'b0, 2'b01, 6'd63, 5'd6, 5'd7), 64'h8000_0000_0000_0000, 2'b00, "R6 min64");
    runVec(mkWord(1'b0, 1'b0, 2'b00, 6'd32, 5'd8, 5'd9), 64'h1234_5678_8000_0000, 2'b11, "R6 min32");
    // R10 zero in both forms
    runVec(mkWord(1'b1, 1'b0, 2'b01, 6'd10, 5'd10, 5'd11), 64'd0, 2'b10, "R10 signed");
    runVec(mkWord(1'b0, 1'b1, 2'b00, 6'd40, 5'd12, 5'd13), 64'hFFFF_FFFF_0000_0000, 2'b01, "R10 unsigned");
    // R8 ties and directed modes
    runVec(mkWord(1'b1, 1'b1, 2'b00, 6'd63, 5'd1, 5'd1), 64'h100_0001, 2'b00, "R8 tie even down");
    runVec(mkWord(1'b1, 1'b1, 2'b00, 6'd63, 5'd1, 5'd1), 64'h100_0003, 2'b00, "R8 tie odd up");
    runVec(mkWord(1'b1, 1'b0, 2'b00, 6'd63, 5'd2, 5'd3), -64'sd16777217, 2'b01, "R8 toward plus");
    runVec(mkWord(1'b1, 1'b0, 2'b00, 6'd63, 5'd2, 5'd3), -64'sd16777217, 2'b10, "R8 toward minus");
    runVec(mkWord(1'b1, 1'b0, 2'b00, 6'd63, 5'd2, 5'd3), -64'sd16777217, 2'b11, "R8 toward zero");
    // R9 exact value leaves inexact low
    runVec(mkWord(1'b1, 1'b1, 2'b00, 6'd50, 5'd14, 5'd15), 64'h100_0000, 2'b00, "R9 exact");
    // R7 all ones rounds into next binade
    runVec(mkWord(1'b1, 1'b1, 2'b01, 6'd63, 5'd16, 5'd17), 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, "R7 carry");
    runVec(mkWord(1'b1, 1'b1, 2'b01, 6'd63, 5'd16, 5'd17), 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, "R7 truncate");
    // R4 narrow source ignores the upper half
    runVec(mkWord(1'b0, 1'b1, 2'b01, 6'd63, 5'd18, 5'd19), 64'hDEAD_BEEF_0000_0005, 2'b00, "R4 unsigned");
    runVec(mkWord(1'b0, 1'b0, 2'b01, 6'd60, 5'd18, 5'd19), 64'h0000_0000_FFFF_FFFB, 2'b00, "R4 signed");
    // R3 single lands low, double uses the full word
    runVec(mkWord(1'b1, 1'b0, 2'b00, 6'd62, 5'd20, 5'd21), 64'h0123_4567_89AB_CDEF, 2'b00, "R3 single");
    runVec(mkWord(1'b1, 1'b0, 2'b01, 6'd62, 5'd20, 5'd21), 64'h0123_4567_89AB_CDEF, 2'b00, "R3 double");
    // R2 undefined encodings
    runVec(mkWord(1'b1, 1'b0, 2'b10, 6'd63, 5'd22, 5'd23), 64'd77, 2'b00, "R2 type10");
    runVec(mkWord(1'b1, 1'b1, 2'b11, 6'd63, 5'd22, 5'd23), 64'd77, 2'b00, "R2 type11");
    runVec(mkWord(1'b0, 1'b0, 2'b00, 6'd31, 5'd24, 5'd25), 64'd77, 2'b00, "R2 narrow scale");
    // R1 word outside the conversion class; R11 indices still reported
    w = mkWord(1'b1, 1'b0, 2'b01, 6'd63, 5'd26, 5'd27);
    w[21:17] = 5'b01100;
    runVec(w, 64'd5, 2'b00, "R1 R11 foreign word");

    for (int n = 0; n < 3000; n++) begin
      logic       sf, uns;
      logic [1:0] typ;
      logic [5:0] sc;
      sf  = 1'($urandom());
      uns = 1'($urandom());
      typ = (($urandom() % 16) == 0) ? 2'($urandom()) : {1'b0, 1'($urandom())};
      sc  = 6'($urandom());
      if (!sf && (($urandom() % 10) != 0)) sc[5] = 1'b1;
      case ($urandom() % 4)
        0: s = 64'($urandom() % 1000);
        1: s = {32'($urandom()), 32'($urandom())};
        2: s = {32'($urandom()), 32'($urandom())} >> ($urandom() % 64);
        default: s = 64'h8000_0000_0000_0000 | 64'($urandom());
      endcase
      runVec(mkWord(sf, uns, typ, sc, 5'($urandom()), 5'($urandom())), s, 2'($urandom()),
             "R4/R5/R6/R7/R8/R9 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule